// File: doc/BRIEF.md
# Console Transmit Register Interface

This block is the register-facing half of a serial console transmitter. A processor reaches it through a small write/read port with two locations: a status word and a character word. Writing a character latches its low byte, marks the transmitter busy and offers the byte to a downstream sink (typically a UART shifter) over a valid/ready handshake. The byte is held on the sink port for as long as the sink refuses it. Once the sink takes it, an optional completion delay runs, after which the block reports itself ready again and, if the processor enabled it, raises a level interrupt.

Before the byte reaches the sink it passes through a character conversion chosen by a mode input. The modes are an 8-bit pass-through, a 7-bit form with the top bit forced low, and a 7-bit form whose top bit carries parity over the lower seven bits. Reset leaves the transmitter idle and ready, with the interrupt enable off.

Top module: `contx_regif`

## Requirements
- R1: After reset the status word reads 0x0080 (ready set, enable clear), `irq_o` is low and `snk_valid_o` is low.
- R2: With `reg_sel_i` = 0 the read port returns ready in bit 7 and enable in bit 6 with every other bit zero; only bit 6 can be written. With `reg_sel_i` = 1 it reads zero.
- R3: A status write with bit 6 = 0 leaves `irq_o` low from the next cycle on.
- R4: A status write with bit 6 = 1 while ready is set and enable was clear drives `irq_o` high on the next cycle.
- R5: A character write (`reg_sel_i` = 1) keeps only bits 7:0; on the next cycle ready is clear, `irq_o` is low and `snk_valid_o` is high.
- R6: While `snk_ready_i` is low, `snk_valid_o` stays high, the offered byte does not change and ready stays clear.
- R7: With the sink accepting in cycle T (valid and ready both high), ready reads 1 from cycle T+1+`delay_i`; `delay_i` = 0 gives ready in cycle T+1.
- R8: When ready is set by a completed transfer, `irq_o` rises with it if enable is set and stays low if enable is clear.
- R9: Mode 0 (and the unused code 3) passes the byte to the sink unchanged.
- R10: Mode 1 sends the byte with bit 7 forced to 0.
- R11: Mode 2 sends bits 6:0 unchanged and sets bit 7 so that the eight bits hold an even number of ones (with the default parity parameter).
- R12: A character write while an earlier byte is still waiting replaces it; only the new byte reaches the sink, and ready stays clear until that byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_sel_i | input | 1 | Register select: 0 status word, 1 character word |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data for the selected register (combinational) |
| mode_i | input | 2 | Character conversion mode |
| delay_i | input | DLY_W | Cycles between sink acceptance and ready |
| snk_valid_o | output | 1 | A byte is offered to the sink |
| snk_data_o | output | 8 | Converted byte offered to the sink |
| snk_ready_i | input | 1 | Sink takes the offered byte this cycle |
| irq_o | output | 1 | Level transmit interrupt |

## Verification
The assertions watch, on every cycle, the register side effects of each write (a character write clearing ready and the interrupt, enable writes clearing or arming it), that the interrupt never stands without enable, that ready and a pending byte never coexist, and that a refused byte is held unchanged. Only the bench scenarios show the data path: the converted byte for each mode compared through a scoreboard, the exact cycle at which ready returns for zero and non-zero delays, and that a replaced byte never reaches the sink.

// File: rtl/contx_pkg.sv
package contx_pkg;

   localparam int CHAR_W   = 8;
   localparam int RDY_POS  = 7;
   localparam int IE_POS   = 6;

   typedef enum logic [1:0] {
      MODE_RAW   = 2'd0,
      MODE_STRIP = 2'd1,
      MODE_PAR   = 2'd2,
      MODE_SPARE = 2'd3
   } txmode_e;

endpackage

// File: rtl/contx_conv.sv
module contx_conv
   import contx_pkg::*;
#(
   parameter bit PAR_ODD = 1'b0
) (
   input  logic [CHAR_W-1:0] raw_i,
   input  logic [1:0]        mode_i,
   output logic [CHAR_W-1:0] char_o
);

   localparam int LOW_W = CHAR_W - 1;

   logic par_bit;
   txmode_e mode;

   assign mode = txmode_e'(mode_i);

   generate
      if (PAR_ODD) begin : g_odd
         assign par_bit = ~(^raw_i[LOW_W-1:0]);
      end else begin : g_even
         assign par_bit = ^raw_i[LOW_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (mode)
         MODE_STRIP: char_o = {1'b0, raw_i[LOW_W-1:0]};
         MODE_PAR:   char_o = {par_bit, raw_i[LOW_W-1:0]};
         default:    char_o = raw_i;
      endcase
   end

endmodule

// File: rtl/contx_hold.sv
module contx_hold #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_data_i,
   input  logic         ready_i,
   output logic         valid_o,
   output logic [W-1:0] data_o,
   output logic         accept_o
);

   logic         valid_q;
   logic [W-1:0] buf_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         buf_q   <= '0;
      end else if (load_i) begin
         valid_q <= 1'b1;
         buf_q   <= load_data_i;
      end else if (valid_q && ready_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o  = valid_q;
   assign data_o   = buf_q;
   assign accept_o = valid_q && ready_i;

endmodule

// File: rtl/contx_cmpl.sv
module contx_cmpl #(
   parameter int DLY_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             accept_i,
   input  logic             cancel_i,
   input  logic [DLY_W-1:0] delay_i,
   output logic             fire_o
);

   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   logic             busy_q;
   logic [DLY_W-1:0] cnt_q;
   logic             zero_dly;

   assign zero_dly = (delay_i == '0);
   assign fire_o   = !cancel_i &&
                     ((accept_i && zero_dly) || (busy_q && cnt_q == ONE));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (cancel_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept_i) begin
         busy_q <= !zero_dly;
         cnt_q  <= delay_i;
      end else if (busy_q) begin
         cnt_q <= cnt_q - ONE;
         if (cnt_q == ONE) busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/contx_regif.sv
module contx_regif
   import contx_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter int DLY_W   = 8,
   parameter bit PAR_ODD = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             reg_wr_i,
   input  logic             reg_sel_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   output logic [REG_W-1:0] reg_rdata_o,
   input  logic [1:0]       mode_i,
   input  logic [DLY_W-1:0] delay_i,
   output logic             snk_valid_o,
   output logic [7:0]       snk_data_o,
   input  logic             snk_ready_i,
   output logic             irq_o
);

   generate
      if (REG_W < CHAR_W) begin : g_bad_regw
         $error("contx_regif: REG_W must hold a full character");
      end
      if (DLY_W < 1) begin : g_bad_dlyw
         $error("contx_regif: DLY_W must be at least 1");
      end
   endgenerate

   logic stat_wr, char_wr;
   logic rdy_q, ie_q, irq_q;
   logic ie_nxt;
   logic accept, fire;
   logic [CHAR_W-1:0] hold_q;
   logic unused_wdata_hi;

   assign stat_wr = reg_wr_i && !reg_sel_i;
   assign char_wr = reg_wr_i &&  reg_sel_i;
   assign ie_nxt  = stat_wr ? reg_wdata_i[IE_POS] : ie_q;
   assign unused_wdata_hi = ^reg_wdata_i[REG_W-1:CHAR_W];

   contx_hold #(.W(CHAR_W)) i_hold (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (char_wr),
      .load_data_i (reg_wdata_i[CHAR_W-1:0]),
      .ready_i     (snk_ready_i),
      .valid_o     (snk_valid_o),
      .data_o      (hold_q),
      .accept_o    (accept)
   );

   contx_cmpl #(.DLY_W(DLY_W)) i_cmpl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .accept_i (accept),
      .cancel_i (char_wr),
      .delay_i  (delay_i),
      .fire_o   (fire)
   );

   contx_conv #(.PAR_ODD(PAR_ODD)) i_conv (
      .raw_i  (hold_q),
      .mode_i (mode_i),
      .char_o (snk_data_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rdy_q <= 1'b1;
         ie_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         ie_q <= ie_nxt;
         if (char_wr) begin
            rdy_q <= 1'b0;
            irq_q <= 1'b0;
         end else begin
            if (fire) rdy_q <= 1'b1;
            if (stat_wr && !reg_wdata_i[IE_POS]) begin
               irq_q <= 1'b0;
            end else if (stat_wr && !ie_q && rdy_q) begin
               irq_q <= 1'b1;
            end else if (fire && ie_nxt) begin
               irq_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      if (!reg_sel_i) begin
         reg_rdata_o[RDY_POS] = rdy_q;
         reg_rdata_o[IE_POS]  = ie_q;
      end
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/contx_chk.sv
module contx_chk #(
   parameter int REG_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             reg_wr_i,
   input logic             reg_sel_i,
   input logic             wr_ie_i,
   input logic [REG_W-1:0] reg_rdata_o,
   input logic             snk_valid_o,
   input logic             snk_ready_i,
   input logic             irq_o,
   input logic             rdy_q,
   input logic             ie_q,
   input logic [7:0]       hold_q
);

   localparam logic [REG_W-1:0] STAT_MASK = REG_W'(16'h00C0);

   assert_rd_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_sel_i |-> ((reg_rdata_o & ~STAT_MASK) == '0));

   assert_rd_char_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_sel_i |-> (reg_rdata_o == '0));

   assert_ie_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && !reg_sel_i && !wr_ie_i) |=> !irq_o);

   assert_arm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && !reg_sel_i && wr_ie_i && !ie_q && rdy_q) |=> irq_o);

   assert_char_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_sel_i) |=> (!rdy_q && !irq_o && snk_valid_o));

   assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snk_valid_o && !snk_ready_i && !(reg_wr_i && reg_sel_i))
      |=> (snk_valid_o && $stable(hold_q) && !rdy_q));

   assert_ready_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdy_q |-> !snk_valid_o);

   assert_irq_needs_ie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ie_q);

endmodule

bind contx_regif contx_chk #(.REG_W(REG_W)) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .reg_wr_i    (reg_wr_i),
   .reg_sel_i   (reg_sel_i),
   .wr_ie_i     (reg_wdata_i[contx_pkg::IE_POS]),
   .reg_rdata_o (reg_rdata_o),
   .snk_valid_o (snk_valid_o),
   .snk_ready_i (snk_ready_i),
   .irq_o       (irq_o),
   .rdy_q       (rdy_q),
   .ie_q        (ie_q),
   .hold_q      (hold_q)
);

// File: tb/test_contx_regif.sv
module test_contx_regif;

   localparam int REG_W = 16;
   localparam int DLY_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic             reg_sel = 1'b0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;
   logic [1:0]       mode = 2'd0;
   logic [DLY_W-1:0] delay = '0;
   logic             snk_valid;
   logic [7:0]       snk_data;
   logic             snk_ready = 1'b1;
   logic             irq;

   int checks = 0;
   int errors = 0;
   int accepted = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   contx_regif #(.REG_W(REG_W), .DLY_W(DLY_W)) i_contx_regif (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_wr_i    (reg_wr),
      .reg_sel_i   (reg_sel),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .mode_i      (mode),
      .delay_i     (delay),
      .snk_valid_o (snk_valid),
      .snk_data_o  (snk_data),
      .snk_ready_i (snk_ready),
      .irq_o       (irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] model(input logic [7:0] b, input logic [1:0] m);
      case (m)
         2'd1:    return {1'b0, b[6:0]};
         2'd2:    return {^b[6:0], b[6:0]};
         default: return b;
      endcase
   endfunction

   // monitor: compares every accepted byte with the scoreboard
   always @(negedge clk) begin
      if (rst_n && snk_valid && snk_ready) begin
         accepted++;
         if (exp_q.size() == 0) begin
            chk("R12 unexpected byte", {8'h00, snk_data}, 16'hxxxx);
         end else begin
            chk(tag_q.pop_front(), {8'h00, snk_data}, {8'h00, exp_q.pop_front()});
         end
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic reg_write(input logic sel, input logic [15:0] d);
      @(posedge clk);
      #1;
      reg_wr = 1'b1;
      reg_sel = sel;
      reg_wdata = d;
      @(posedge clk);
      #1;
      reg_wr = 1'b0;
      reg_sel = 1'b0;
   endtask

   task automatic read_status(output logic [15:0] v);
      reg_sel = 1'b0;
      #1;
      v = reg_rdata;
   endtask

   // driver: pushes the expected sink byte and writes the character
   task automatic send(input logic [7:0] b, input string req, input bit replace);
      if (replace) begin
         void'(exp_q.pop_back());
         void'(tag_q.pop_back());
      end
      exp_q.push_back(model(b, mode));
      tag_q.push_back(req);
      reg_write(1'b1, {8'hA6, b});
   endtask

   task automatic wait_ready();
      logic [15:0] s;
      for (int i = 0; i < 50; i++) begin
         read_status(s);
         if (s[7]) break;
         step(1);
      end
   endtask

   initial begin
      #(8 * 100000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] s;
      step(3);
      rst_n = 1'b1;

      // R1 reset state
      read_status(s);
      chk("R1 status", s, 16'h0080);
      chk("R1 irq", {15'd0, irq}, 16'd0);
      chk("R1 valid", {15'd0, snk_valid}, 16'd0);

      // R2/R4 enable write arms irq while ready
      reg_write(1'b0, 16'hFFFF);
      chk("R4 irq armed", {15'd0, irq}, 16'd1);
      read_status(s);
      chk("R2 status bits", s, 16'h00C0);
      reg_sel = 1'b1;
      #1;
      chk("R2 char read zero", reg_rdata, 16'h0000);
      reg_sel = 1'b0;

      // R3 enable clear drops irq
      reg_write(1'b0, 16'h0000);
      chk("R3 irq cleared", {15'd0, irq}, 16'd0);
      read_status(s);
      chk("R3 status", s, 16'h0080);

      // R5/R9 pass-through, enable off
      send(8'hC3, "R9 raw byte", 1'b0);
      read_status(s);
      chk("R5 ready clear", s, 16'h0000);
      chk("R5 valid", {15'd0, snk_valid}, 16'd1);
      chk("R5 low byte only", {8'h00, snk_data}, 16'h00C3);
      step(1);
      read_status(s);
      chk("R7 ready after accept", s, 16'h0080);
      chk("R8 no irq when disabled", {15'd0, irq}, 16'd0);

      // R8 completion interrupt with enable set
      reg_write(1'b0, 16'h0040);
      send(8'h41, "R9 raw byte 2", 1'b0);
      chk("R5 irq cleared by write", {15'd0, irq}, 16'd0);
      step(1);
      chk("R8 irq on completion", {15'd0, irq}, 16'd1);
      reg_write(1'b0, 16'h0000);

      // R10 strip mode
      mode = 2'd1;
      send(8'hFF, "R10 strip", 1'b0);
      wait_ready();
      send(8'h80, "R10 strip zero", 1'b0);
      wait_ready();

      // R11 parity mode
      mode = 2'd2;
      send(8'h03, "R11 even parity 2 ones", 1'b0);
      wait_ready();
      send(8'h87, "R11 even parity 3 ones", 1'b0);
      wait_ready();

      // R9 spare code behaves as pass-through
      mode = 2'd3;
      send(8'h9A, "R9 spare mode", 1'b0);
      wait_ready();
      mode = 2'd0;

      // R6 sink stall
      snk_ready = 1'b0;
      send(8'h55, "R6 held byte", 1'b0);
      step(6);
      chk("R6 valid held", {15'd0, snk_valid}, 16'd1);
      chk("R6 data held", {8'h00, snk_data}, 16'h0055);
      read_status(s);
      chk("R6 ready clear", s, 16'h0000);
      snk_ready = 1'b1;
      step(1);
      chk("R6 released", {15'd0, snk_valid}, 16'd0);
      read_status(s);
      chk("R7 ready after stall", s, 16'h0080);

      // R7 non-zero completion delay
      delay = 8'd3;
      send(8'h2C, "R7 delayed byte", 1'b0);
      step(3);
      read_status(s);
      chk("R7 ready still clear", s, 16'h0000);
      step(1);
      read_status(s);
      chk("R7 ready after delay", s, 16'h0080);
      delay = '0;

      // R12 replacement of a waiting byte
      snk_ready = 1'b0;
      send(8'h11, "R12 first", 1'b0);
      send(8'h22, "R12 replacement", 1'b1);
      step(2);
      read_status(s);
      chk("R12 ready clear", s, 16'h0000);
      chk("R12 new byte offered", {8'h00, snk_data}, 16'h0022);
      snk_ready = 1'b1;
      step(1);
      read_status(s);
      chk("R12 ready after accept", s, 16'h0080);
      step(2);

      chk("R12 scoreboard empty", 16'(exp_q.size()), 16'd0);
      chk("R12 bytes accepted", 16'(accepted), 16'd10);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule